// File: doc/BRIEF.md
# Dual-Rail Acknowledged Serial Link

This block moves bytes across two open-drain wires without any shared clock on the wires. One wire stands for a zero and the other for a one. Both wires float high when nothing is happening. The sending side announces a bit by pulling low the wire that carries its value. The receiving side answers by pulling the other wire low. The sender then lets go. The receiver sees the release and lets go too. The next bit may begin only when both wires are high again. Each bit is therefore a full four-phase exchange, so the link always runs at the pace of whichever side is slower.

The top module holds one sender and one receiver. In a system they sit on two different devices; here they share a clock so that the pair can be checked end to end. The sender takes a byte through a valid/ready handshake and sends eight bit exchanges, lowest bit first. The receiver presents each finished byte with a single-cycle valid pulse. Each side exposes its pull-down enables and reads the wire levels back through its own two-flop synchronizer. The wired-AND of the wires is built outside the block.

Each side has a timer. If any phase stays waiting for `TIMEOUT` cycles, that side aborts the byte and sets its own sticky error flag. The sender has states TX_IDLE, TX_DRIVE and TX_SETTLE, with these transitions:
- TX_IDLE→TX_DRIVE on an accepted byte.
- TX_DRIVE→TX_SETTLE when both wires read low.
- TX_SETTLE→TX_DRIVE when both wires read high and bits remain.
- TX_SETTLE→TX_IDLE after the last bit.
- TX_DRIVE or TX_SETTLE→TX_IDLE on timeout.

The receiver has states RX_LISTEN, RX_ACK and RX_DRAIN, with these transitions:
- RX_LISTEN→RX_ACK when exactly one wire reads low.
- RX_ACK→RX_DRAIN when the data wire reads high again.
- RX_DRAIN→RX_LISTEN when both wires read high.
- Any state→RX_DRAIN on timeout.

Top module: `duallink_top`

## Requirements
- R1: After reset both pull-down vectors are 0, `tx_ready_o` is 1 while both wires are high, `rx_valid_o` is 0 and both error flags are 0.
- R2: Pull vectors use bit 0 for the zero wire and bit 1 for the one wire. The sender pulls only the wire matching the current bit (2'b01 for a 0, 2'b10 for a 1), never both, and sends bit 0 of the byte first.
- R3: The receiver acknowledges by pulling the wire opposite to the data wire, and only after its synchronized view showed exactly one wire low.
- R4: The sender releases its data wire only after its synchronized view showed both wires low, unless it timed out.
- R5: A new bit starts only after the sender saw both wires high, so the acknowledge of the previous bit has already been released. With no delay from the wires, bits start 12 cycles apart.
- R6: A byte accepted at clock edge E appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse after edge E+93 when the wires add no delay. The bits are reassembled lowest first.
- R7: While the receiver is idle, a period in which both wires are low causes no acknowledge, does not start the receiver's timer, and does not shift the bit position of the next byte.
- R8: If a sender phase waits `TIMEOUT` cycles, the sender releases its wire and returns to TX_IDLE at edge entry+`TIMEOUT`. `tx_err_o` then stays 1 until reset.
- R9: If a receiver phase waits `TIMEOUT` cycles, including the gap between bits inside a byte, the receiver drops its acknowledge, discards the partial byte and sets `rx_err_o`, which stays 1 until reset.
- R10: `tx_ready_o` is 1 only in TX_IDLE while both synchronized wires are high. After a sender abort it rises 2 cycles after the wire is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data_i | input | DATA_W | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Sender accepts a byte this cycle |
| tx_pull_o | output | 2 | Sender pull-down enables (bit 0 zero wire, bit 1 one wire) |
| tx_line_i | input | 2 | Wire levels as seen by the sender |
| tx_err_o | output | 1 | Sticky sender timeout flag |
| rx_line_i | input | 2 | Wire levels as seen by the receiver |
| rx_pull_o | output | 2 | Receiver pull-down enables |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse when a byte completes |
| rx_err_o | output | 1 | Sticky receiver timeout flag |

## Verification
Every change of a wire reaches the opposite state machine three edges later: two synchronizer flops and then the state register. One bit therefore takes 12 cycles:
- The receiver acknowledges at +3.
- The sender releases at +6.
- The receiver drops its acknowledge at +9.
- The next bit starts at +12.

The byte's valid pulse is due after edge E+93 and `tx_ready_o` returns after E+96. The bench's behavioural model stores the accept edge and byte. At every falling clock edge it compares ready, valid, data, each bit's start cycle and wire choice against those offsets. Timeout checks sample one cycle before and at entry+`TIMEOUT`, and the ready check after an abort looks at +1 and +2.

// File: rtl/dl_pkg.sv
package dl_pkg;
    localparam int LINE_N    = 2;
    localparam int LINE_ZERO = 0;
    localparam int LINE_ONE  = 1;

    typedef logic [LINE_N-1:0] line_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DRIVE,
        TX_SETTLE
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_LISTEN,
        RX_ACK,
        RX_DRAIN
    } rx_state_e;
endpackage

// File: rtl/dl_sync2.sv
module dl_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Wires idle high, so both stages reset to 1.
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g]   <= 1'b1;
                stable_q[g] <= 1'b1;
            end else begin
                meta_q[g]   <= d_i[g];
                stable_q[g] <= meta_q[g];
            end
        end
    end

    assign q_o = stable_q;
endmodule

// File: rtl/dl_phase_timer.sv
module dl_phase_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || !run_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/dl_sender.sv
module dl_sender
    import dl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  line_t             line_s_i,
    output line_t             pull_o,
    output logic              err_o
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] word_q, word_d;
    logic [BW-1:0]     pos_q, pos_d;
    logic              err_q, err_d;
    logic              expired;
    logic              restart;
    logic              wires_high;
    logic              wires_low;
    logic              last_bit;
    logic              cur_bit;

    assign wires_high = &line_s_i;
    assign wires_low  = ~|line_s_i;
    assign last_bit   = (pos_q == BW'(DATA_W - 1));
    assign cur_bit    = word_q[pos_q];
    assign restart    = (state_d != state_q) || expired;

    dl_phase_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q != TX_IDLE),
        .restart_i (restart),
        .expired_o (expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
            pos_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            pos_q   <= pos_d;
            err_q   <= err_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        pos_d   = pos_q;
        err_d   = err_q;
        unique case (state_q)
            TX_IDLE: begin
                if (valid_i && wires_high) begin
                    word_d  = data_i;
                    pos_d   = '0;
                    state_d = TX_DRIVE;
                end
            end
            TX_DRIVE: begin
                if (expired) begin
                    err_d   = 1'b1;
                    state_d = TX_IDLE;
                end else if (wires_low) begin
                    state_d = TX_SETTLE;
                end
            end
            TX_SETTLE: begin
                if (expired) begin
                    err_d   = 1'b1;
                    state_d = TX_IDLE;
                end else if (wires_high) begin
                    if (last_bit) begin
                        state_d = TX_IDLE;
                    end else begin
                        pos_d   = pos_q + BW'(1);
                        state_d = TX_DRIVE;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pull_o  = '0;
        ready_o = 1'b0;
        unique case (state_q)
            TX_IDLE:   ready_o = wires_high;
            TX_DRIVE: begin
                pull_o[LINE_ONE]  = cur_bit;
                pull_o[LINE_ZERO] = ~cur_bit;
            end
            TX_SETTLE: pull_o = '0;
            default:   pull_o = '0;
        endcase
    end

    assign err_o = err_q;
endmodule

// File: rtl/dl_receiver.sv
module dl_receiver
    import dl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_t             line_s_i,
    output line_t             pull_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state_q, state_d;
    logic [DATA_W-1:0] acc_q, acc_d;
    logic [DATA_W-1:0] out_q, out_d;
    logic [BW-1:0]     pos_q, pos_d;
    logic              bit_q, bit_d;
    logic              valid_q, valid_d;
    logic              err_q, err_d;
    logic              expired;
    logic              restart;
    logic              wires_high;
    logic              single_low;
    logic              data_freed;

    assign wires_high = &line_s_i;
    assign single_low = ^line_s_i;
    assign data_freed = bit_q ? line_s_i[LINE_ONE] : line_s_i[LINE_ZERO];
    assign restart    = (state_d != state_q) || expired;

    dl_phase_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     ((state_q != RX_LISTEN) || (pos_q != '0)),
        .restart_i (restart),
        .expired_o (expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_LISTEN;
            acc_q   <= '0;
            out_q   <= '0;
            pos_q   <= '0;
            bit_q   <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            out_q   <= out_d;
            pos_q   <= pos_d;
            bit_q   <= bit_d;
            valid_q <= valid_d;
            err_q   <= err_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        out_d   = out_q;
        pos_d   = pos_q;
        bit_d   = bit_q;
        valid_d = 1'b0;
        err_d   = err_q;
        unique case (state_q)
            RX_LISTEN: begin
                if (expired) begin
                    err_d   = 1'b1;
                    pos_d   = '0;
                    state_d = RX_DRAIN;
                end else if (single_low) begin
                    // zero wire still high means the one wire is low
                    bit_d   = line_s_i[LINE_ZERO];
                    state_d = RX_ACK;
                end
            end
            RX_ACK: begin
                if (expired) begin
                    err_d   = 1'b1;
                    pos_d   = '0;
                    state_d = RX_DRAIN;
                end else if (data_freed) begin
                    acc_d[pos_q] = bit_q;
                    if (pos_q == BW'(DATA_W - 1)) begin
                        out_d   = acc_d;
                        valid_d = 1'b1;
                        pos_d   = '0;
                    end else begin
                        pos_d = pos_q + BW'(1);
                    end
                    state_d = RX_DRAIN;
                end
            end
            RX_DRAIN: begin
                if (expired) begin
                    err_d = 1'b1;
                    pos_d = '0;
                end else if (wires_high) begin
                    state_d = RX_LISTEN;
                end
            end
            default: state_d = RX_LISTEN;
        endcase
    end

    // Outputs
    always_comb begin
        pull_o = '0;
        unique case (state_q)
            RX_LISTEN: pull_o = '0;
            RX_ACK: begin
                pull_o[LINE_ZERO] = bit_q;
                pull_o[LINE_ONE]  = ~bit_q;
            end
            RX_DRAIN: pull_o = '0;
            default:  pull_o = '0;
        endcase
    end

    assign data_o  = out_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;
endmodule

// File: rtl/duallink_top.sv
module duallink_top
    import dl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [1:0]        tx_pull_o,
    input  logic [1:0]        tx_line_i,
    output logic              tx_err_o,
    input  logic [1:0]        rx_line_i,
    output logic [1:0]        rx_pull_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_err_o
);
    line_t tx_seen;
    line_t rx_seen;

    dl_sync2 #(.W(LINE_N)) u_tx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tx_line_i),
        .q_o   (tx_seen)
    );

    dl_sync2 #(.W(LINE_N)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_line_i),
        .q_o   (rx_seen)
    );

    dl_sender #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_sender (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (tx_data_i),
        .valid_i  (tx_valid_i),
        .ready_o  (tx_ready_o),
        .line_s_i (tx_seen),
        .pull_o   (tx_pull_o),
        .err_o    (tx_err_o)
    );

    dl_receiver #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_receiver (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s_i (rx_seen),
        .pull_o   (rx_pull_o),
        .data_o   (rx_data_o),
        .valid_o  (rx_valid_o),
        .err_o    (rx_err_o)
    );
endmodule

// File: rtl/dl_checker.sv
module dl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_ready_o,
    input logic [1:0] tx_pull_o,
    input logic [1:0] tx_line_i,
    input logic       tx_err_o,
    input logic [1:0] rx_line_i,
    input logic [1:0] rx_pull_o,
    input logic       rx_valid_o,
    input logic       rx_err_o
);
    p_tx_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_pull_o));

    p_rx_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_pull_o));

    // R3 and R7: an acknowledge starts only after exactly one wire was seen low
    p_ack_after_single_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pull_o != 2'b00 && $past(rx_pull_o) == 2'b00) |->
            ($countones($past(rx_line_i, 3)) == 1));

    p_release_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pull_o == 2'b00 && $past(tx_pull_o) != 2'b00) |->
            ($past(tx_line_i, 3) == 2'b00 || tx_err_o));

    p_bit_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pull_o != 2'b00 && $past(tx_pull_o) == 2'b00) |->
            ($past(tx_line_i, 3) == 2'b11));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    p_tx_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_o |=> tx_err_o);

    p_rx_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_o |=> rx_err_o);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> (tx_pull_o == 2'b00));
endmodule

bind duallink_top dl_checker u_chk (.*);

// File: tb/duallink_top_tb_top.sv
module duallink_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 40;
    localparam int BYTE_DONE  = 93;
    localparam int BYTE_FREE  = 96;
    localparam int BIT_CYC    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [1:0] tx_pull, rx_pull;
    logic [1:0] tx_line, rx_line, wire_lv;
    logic       tx_err, rx_err, rx_valid;
    logic [7:0] rx_data;
    logic [1:0] bench_pull = 2'b00;
    logic       isolate = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int got_bytes = 0;
    bit model_on = 1'b0;
    bit busy = 1'b0;
    bit ack_seen = 1'b0;
    int acc_edge = 0;
    int nbit = 0;
    logic [7:0] acc_byte = '0;
    logic [1:0] prev_tx = '0;
    bit done = 1'b0;

    assign wire_lv = ~(tx_pull | rx_pull | bench_pull);
    assign tx_line = wire_lv;
    assign rx_line = isolate ? 2'b11 : wire_lv;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    duallink_top #(.DATA_W(8), .TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .tx_pull_o(tx_pull), .tx_line_i(tx_line), .tx_err_o(tx_err),
        .rx_line_i(rx_line), .rx_pull_o(rx_pull), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .rx_err_o(rx_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Behavioural reference model, compared every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) got_bytes++;
            if (model_on) begin
                automatic bit exp_rdy = !(busy && cyc < acc_edge + BYTE_FREE);
                automatic bit exp_vld = busy && (cyc == acc_edge + BYTE_DONE);
                chk(tx_ready == exp_rdy, "R10 ready", tx_ready, exp_rdy);
                chk(rx_valid == exp_vld, "R6 valid", rx_valid, exp_vld);
                if (exp_vld) chk(rx_data == acc_byte, "R6 data", rx_data, acc_byte);
                if (prev_tx == 2'b00 && tx_pull != 2'b00) begin
                    chk(cyc == acc_edge + BIT_CYC*nbit, "R5 bit start", cyc, acc_edge + BIT_CYC*nbit);
                    chk(tx_pull == (acc_byte[nbit] ? 2'b10 : 2'b01), "R2 wire", tx_pull,
                        acc_byte[nbit] ? 2 : 1);
                    chk(rx_pull == 2'b00, "R5 ack free", rx_pull, 0);
                    nbit++;
                end
                if (tx_pull != 2'b00 && rx_pull != 2'b00) begin
                    chk(rx_pull == ~tx_pull, "R3 opposite", rx_pull, ~tx_pull);
                    ack_seen = 1'b1;
                end
                if (prev_tx != 2'b00 && tx_pull == 2'b00) begin
                    chk(ack_seen, "R4 release", ack_seen, 1);
                    ack_seen = 1'b0;
                end
                if (busy && cyc >= acc_edge + BYTE_FREE) busy = 1'b0;
                if (tx_valid && tx_ready) begin
                    busy = 1'b1;
                    acc_edge = cyc + 1;
                    acc_byte = tx_data;
                    nbit = 0;
                end
            end
            prev_tx = tx_pull;
        end
    end

    task automatic send(input logic [7:0] b, output int edge_no);
        @(posedge clk); #1;
        tx_data = b;
        tx_valid = 1'b1;
        do @(negedge clk); while (!tx_ready);
        edge_no = cyc + 1;
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic at_cyc(input int x);
        do @(negedge clk); while (cyc < x);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int e;
        logic [7:0] pats [6] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h3C};
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(tx_pull == 2'b00 && rx_pull == 2'b00, "R1 pulls", {tx_pull, rx_pull}, 0);
        chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
        chk(!rx_valid && !tx_err && !rx_err, "R1 flags", {rx_valid, tx_err, rx_err}, 0);

        // R2 R3 R4 R5 R6: a run of patterns, checked by the model
        model_on = 1'b1;
        foreach (pats[i]) begin
            send(pats[i], e);
            repeat (BYTE_FREE + 4) @(posedge clk);
        end

        // R7: both wires low while receiver idle
        model_on = 1'b0;
        @(posedge clk); #1 bench_pull = 2'b11;
        repeat (3) @(negedge clk);
        chk(tx_ready == 1'b0, "R10 busy wires", tx_ready, 0);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            chk(rx_pull == 2'b00 && !rx_valid, "R7 no ack", rx_pull, 0);
        end
        chk(rx_err == 1'b0, "R7 no timer", rx_err, 0);
        @(posedge clk); #1 bench_pull = 2'b00;
        repeat (5) @(posedge clk);
        #1 model_on = 1'b1;
        send(8'h5A, e);
        repeat (BYTE_FREE + 4) @(posedge clk);

        // R9: one injected bit, then silence inside the byte
        #1 model_on = 1'b0;
        @(posedge clk); #1 bench_pull = 2'b01;
        do @(negedge clk); while (rx_pull == 2'b00);
        chk(rx_pull == 2'b10, "R3 ack wire", rx_pull, 2);
        @(posedge clk); #1 bench_pull = 2'b00;
        do @(negedge clk); while (rx_pull != 2'b00);
        chk(rx_err == 1'b0, "R9 before", rx_err, 0);
        repeat (TMO + 20) @(posedge clk);
        @(negedge clk);
        chk(rx_err == 1'b1, "R9 timeout", rx_err, 1);
        chk(rx_pull == 2'b00, "R9 released", rx_pull, 0);
        @(posedge clk); #1 model_on = 1'b1;
        send(8'hC3, e);
        repeat (BYTE_FREE + 4) @(posedge clk);
        chk(rx_err == 1'b1, "R9 sticky", rx_err, 1);

        // R8 R10: receiver cut off, sender times out
        #1 model_on = 1'b0;
        isolate = 1'b1;
        send(8'h0F, e);
        at_cyc(e + TMO - 1);
        chk(tx_pull == 2'b10 && !tx_err, "R8 still driving", {tx_pull, tx_err}, 4);
        at_cyc(e + TMO);
        chk(tx_pull == 2'b00, "R8 released", tx_pull, 0);
        chk(tx_err == 1'b1, "R8 error", tx_err, 1);
        at_cyc(e + TMO + 1);
        chk(tx_ready == 1'b0, "R10 sync wait", tx_ready, 0);
        at_cyc(e + TMO + 2);
        chk(tx_ready == 1'b1, "R10 ready back", tx_ready, 1);
        @(posedge clk); #1 isolate = 1'b0;
        repeat (4) @(posedge clk);
        #1 model_on = 1'b1;
        send(8'h96, e);
        repeat (BYTE_FREE + 4) @(posedge clk);
        @(negedge clk);
        chk(tx_err == 1'b1, "R8 sticky", tx_err, 1);
        chk(got_bytes == 9, "R6 byte count", got_bytes, 9);
        finish_run();
    end
endmodule